// File: doc/BRIEF.md
# Table-Based AES-128 Cipher Round

This block computes one encryption round of AES-128 on a 128-bit state. Each of the sixteen state bytes goes through its own synchronous lookup table. The table returns the substituted byte and, when column mixing is built, the GF(2^8) double of that byte as well. The registered table outputs are the only pipeline register in the datapath.

Row rotation costs no logic, because it is only the choice of which state byte feeds which table. Column mixing and round-key addition share one XOR tree per output byte. In that tree, three times the substituted byte is formed as its double XOR the byte itself, so the tables never store a tripled value.

A parameter selects the round type. The normal round mixes columns. The last round of a cipher omits column mixing and builds only the substitution half of each table. A cipher pipeline chains nine normal stages and one last stage behind an initial key whitening. A valid bit travels with the data.

Top module: `aes_round_stage`

## Requirements
- R1: With `FINAL_ROUND`=0, `state_o` equals MixColumns(ShiftRows(SubBytes(s))) XOR `key_i`. Here s is the `state_i` sampled at the previous rising edge. Byte b of every 128-bit bus occupies bits [127-8b -: 8] and sits at row b mod 4, column b div 4. The mixing matrix rows are {02 03 01 01}, {01 02 03 01}, {01 01 02 03} and {03 01 01 02}, over GF(2^8) reduced by x^8+x^4+x^3+x+1.
- R2: With `FINAL_ROUND`=1, `state_o` equals ShiftRows(SubBytes(s)) XOR `key_i`, with no column mixing.
- R3: `state_o` depends only on the `state_i` captured at the last rising edge. A change of `state_i` between edges leaves `state_o` unchanged until the next edge.
- R4: `valid_o` equals `valid_i` delayed by exactly one clock.
- R5: While `rst_ni` is low, `valid_o` is 0, even if `valid_i` is 1.
- R6: The substitution maps 0x00 to 0x63 (multiplicative inverse with zero kept at zero, then the affine map with constant 0x63). An all-zero state with an all-zero key therefore yields sixteen bytes of 0x63 in both round types.
- R7: Output row r, column c is drawn from input row r, column (c+r) mod 4. Row 0 is not rotated, and rows 1, 2 and 3 rotate left by 1, 2 and 3 bytes.
- R8: `key_i` is applied in the cycle the result is presented. Flipping a key bit flips the same bit of `state_o`.
- R9: Nine normal stages followed by one last stage reproduce the AES-128 known answer. Given key 000102…0f and whitened plaintext 00112233…ff, the output is 69c4e0d86a7b0430d8cdb78070b4c55a, exactly ten clocks after the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Qualifies `state_i` |
| state_i | input | 128 | Round input state, byte 0 in the top bits |
| key_i | input | 128 | Round key, applied in the output cycle |
| valid_o | output | 1 | Qualifies `state_o` |
| state_o | output | 128 | Round output state |

## Verification
The bench builds the block with `FINAL_ROUND` at 0 and at 1 side by side, driven by the same stimulus. Both are compared every clock with a behavioural round model that finds each inverse by search. Single-byte patterns make the row rotation visible in the last-round build, where no mixing spreads the byte. A chain of nine normal builds and one last build checks the combined effect of every table and the mixing constants against the public known-answer vector, and also checks the ten-clock latency.

// File: rtl/aes_rs_pkg.sv
package aes_rs_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_ROWS  = 4;
  localparam int unsigned N_COLS  = 4;
  localparam int unsigned N_BYTES = N_ROWS * N_COLS;
  localparam int unsigned STATE_W = N_BYTES * BYTE_W;
  localparam int unsigned COL_W   = N_ROWS * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t gf_x2(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t p = '0;
    byte_t x = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) p = p ^ x;
      x = gf_x2(x);
    end
    return p;
  endfunction

  // a^254 is the inverse; zero stays zero
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r = 8'h01;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (i != 0) r = gf_mul(r, a);
    end
    return r;
  endfunction

  function automatic byte_t sub_byte(input byte_t a);
    byte_t v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/sbox_dbl_table.sv
module sbox_dbl_table
  import aes_rs_pkg::*;
#(
  parameter bit DBL_EN = 1'b1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [BYTE_W-1:0]             addr_i,
  output logic [(DBL_EN ? 16 : 8)-1:0]  data_o
);
  localparam int unsigned OUT_W = DBL_EN ? 2 * BYTE_W : BYTE_W;

  logic [OUT_W-1:0] word;

  if (DBL_EN) begin : g_dbl
    always_comb begin
      word = {gf_x2(sub_byte(addr_i)), sub_byte(addr_i)};
    end
  end else begin : g_sub
    always_comb begin
      word = sub_byte(addr_i);
    end
  end

  // registered read: this is the stage register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= word;
  end
endmodule

// File: rtl/col_mix_key.sv
module col_mix_key
  import aes_rs_pkg::*;
(
  input  logic [0:N_ROWS-1][BYTE_W-1:0] sub_i,
  input  logic [0:N_ROWS-1][BYTE_W-1:0] dbl_i,
  input  logic [0:N_ROWS-1][BYTE_W-1:0] key_i,
  output logic [0:N_ROWS-1][BYTE_W-1:0] col_o
);
  // 3*s folded as dbl^sub into the key XOR tree
  always_comb begin
    for (int r = 0; r < N_ROWS; r++) begin
      col_o[r] = dbl_i[r]
               ^ dbl_i[(r + 1) % N_ROWS] ^ sub_i[(r + 1) % N_ROWS]
               ^ sub_i[(r + 2) % N_ROWS]
               ^ sub_i[(r + 3) % N_ROWS]
               ^ key_i[r];
    end
  end
endmodule

// File: rtl/aes_round_stage.sv
module aes_round_stage
  import aes_rs_pkg::*;
#(
  parameter bit FINAL_ROUND = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [STATE_W-1:0] key_i,
  output logic               valid_o,
  output logic [STATE_W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic [0:N_ROWS-1][BYTE_W-1:0] key_col;
    logic [0:N_ROWS-1][BYTE_W-1:0] out_col;

    assign key_col = key_i[STATE_W-1-c*COL_W -: COL_W];
    assign state_o[STATE_W-1-c*COL_W -: COL_W] = out_col;

    if (!FINAL_ROUND) begin : g_mix
      logic [0:N_ROWS-1][BYTE_W-1:0] sub_col;
      logic [0:N_ROWS-1][BYTE_W-1:0] dbl_col;

      for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        // row shift by wiring: source column (c+r) mod 4
        localparam int unsigned SRC = N_ROWS * ((c + r) % N_COLS) + r;
        logic [2*BYTE_W-1:0] tword;
        sbox_dbl_table #(.DBL_EN(1'b1)) u_tab (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .addr_i (state_i[STATE_W-1-SRC*BYTE_W -: BYTE_W]),
          .data_o (tword)
        );
        assign sub_col[r] = tword[BYTE_W-1:0];
        assign dbl_col[r] = tword[2*BYTE_W-1:BYTE_W];
      end

      col_mix_key u_mix (
        .sub_i (sub_col),
        .dbl_i (dbl_col),
        .key_i (key_col),
        .col_o (out_col)
      );
    end else begin : g_last
      for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        localparam int unsigned SRC = N_ROWS * ((c + r) % N_COLS) + r;
        logic [BYTE_W-1:0] tword;
        sbox_dbl_table #(.DBL_EN(1'b0)) u_tab (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .addr_i (state_i[STATE_W-1-SRC*BYTE_W -: BYTE_W]),
          .data_o (tword)
        );
        assign out_col[r] = tword ^ key_col[r];
      end
    end
  end
endmodule

// File: rtl/aes_round_stage_chk.sv
module aes_round_stage_chk
  import aes_rs_pkg::*;
#(
  parameter bit FINAL_ROUND = 1'b0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [STATE_W-1:0] state_i,
  input logic [STATE_W-1:0] key_i,
  input logic               valid_o,
  input logic [STATE_W-1:0] state_o
);
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R4
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0) |-> (valid_o == $past(valid_i)));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && $past(state_i) == $past(state_i, 2) && $stable(key_i))
      |-> $stable(state_o));

  // R6
  zero_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && $past(state_i) == '0 && key_i == '0)
      |-> (state_o == {N_BYTES{8'h63}}));

  if (FINAL_ROUND) begin : g_last
    // R7: row 1, column 0 comes from byte 5
    row1_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q != 2'd0 && $past(state_i[87:80]) == 8'h00 && key_i[119:112] == 8'h00)
        |-> (state_o[119:112] == 8'h63));
    // R7: row 0 is not rotated
    row0_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q != 2'd0 && $past(state_i[127:120]) == 8'h00 && key_i[127:120] == 8'h00)
        |-> (state_o[127:120] == 8'h63));
  end
endmodule

bind aes_round_stage aes_round_stage_chk #(.FINAL_ROUND(FINAL_ROUND)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .state_i (state_i),
  .key_i   (key_i),
  .valid_o (valid_o),
  .state_o (state_o)
);

// File: tb/test_aes_round_stage.sv
module test_aes_round_stage;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] state_i = '0;
  logic [127:0] key_i = '0;
  logic         valid_o, valid_last_o;
  logic [127:0] state_o, state_last_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]   sb [256];
  logic [127:0] rk [11];

  logic [127:0] ch_in = '0;
  logic         ch_vin = 1'b0;
  wire  [127:0] ch_s [11];
  wire          ch_v [11];

  logic [127:0] q_n [$];
  logic [127:0] q_f [$];
  logic         q_v [$];
  string        q_t [$];
  logic [127:0] last_n;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  aes_round_stage #(.FINAL_ROUND(1'b0)) i_aes_round_stage (
    .clk_i, .rst_ni, .valid_i, .state_i, .key_i,
    .valid_o (valid_o), .state_o (state_o)
  );

  aes_round_stage #(.FINAL_ROUND(1'b1)) i_aes_round_stage_last (
    .clk_i, .rst_ni, .valid_i, .state_i, .key_i,
    .valid_o (valid_last_o), .state_o (state_last_o)
  );

  assign ch_s[0] = ch_in;
  assign ch_v[0] = ch_vin;

  for (genvar g = 0; g < 10; g++) begin : g_chain
    if (g < 9) begin : g_n
      aes_round_stage #(.FINAL_ROUND(1'b0)) u_st (
        .clk_i, .rst_ni, .valid_i (ch_v[g]), .state_i (ch_s[g]),
        .key_i (rk[g+1]), .valid_o (ch_v[g+1]), .state_o (ch_s[g+1])
      );
    end else begin : g_f
      aes_round_stage #(.FINAL_ROUND(1'b1)) u_st (
        .clk_i, .rst_ni, .valid_i (ch_v[g]), .state_i (ch_s[g]),
        .key_i (rk[g+1]), .valid_o (ch_v[g+1]), .state_o (ch_s[g+1])
      );
    end
  end

  function automatic int b_mul(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b & 1) p ^= a;
      a = a << 1;
      if (a & 256) a ^= 'h11b;
      b = b >> 1;
    end
    return p & 255;
  endfunction

  function automatic logic [127:0] round_ref(logic [127:0] s, logic [127:0] k, bit fin);
    logic [7:0] a [16];
    logic [7:0] t [16];
    logic [7:0] o [16];
    logic [127:0] res;
    for (int b = 0; b < 16; b++) a[b] = s[127-8*b -: 8];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        t[4*c+r] = sb[a[4*((c+r)%4)+r]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        if (fin) o[4*c+r] = t[4*c+r];
        else o[4*c+r] = 8'(b_mul(2, t[4*c+r]) ^ b_mul(3, t[4*c+(r+1)%4]))
                        ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
    for (int b = 0; b < 16; b++) res[127-8*b -: 8] = o[b] ^ k[127-8*b -: 8];
    return res;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // compare the previous cycle's result, then drive the next input
  task automatic step(logic [127:0] s, logic [127:0] k, logic v, string tag, bit probe);
    @(negedge clk_i);
    if (q_n.size() > 0) begin
      string t;
      t = q_t.pop_front();
      last_n = q_n.pop_front();
      chk({t, " normal"}, state_o, last_n);
      chk({t, " last"}, state_last_o, q_f.pop_front());
      chk("R4 valid", {127'b0, valid_o}, {127'b0, q_v[0]});
      chk("R4 valid last", {127'b0, valid_last_o}, {127'b0, q_v.pop_front()});
    end
    state_i = s;
    valid_i = v;
    if (!probe) key_i = k;
    if (probe) begin
      #1;
      chk("R3 output holds after input change", state_o, last_n);
    end
    q_n.push_back(round_ref(s, key_i, 1'b0));
    q_f.push_back(round_ref(s, key_i, 1'b1));
    q_v.push_back(v);
    q_t.push_back(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w [44];
    logic [7:0]  rc;
    logic [127:0] kfix;
    logic [127:0] hs;

    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv;
      logic [7:0] v;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (b_mul(x, y) == 1) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        v[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
             ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
      sb[x] = v;
    end

    kfix = 128'h000102030405060708090a0b0c0d0e0f;
    for (int i = 0; i < 4; i++) w[i] = kfix[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t;
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
        rc = 8'(b_mul(2, rc));
      end
      w[i] = w[i-4] ^ t;
    end
    for (int j = 0; j < 11; j++) rk[j] = {w[4*j], w[4*j+1], w[4*j+2], w[4*j+3]};

    // reset with valid_i high
    valid_i = 1'b1;
    state_i = rnd128();
    repeat (3) @(negedge clk_i);
    chk("R5 reset valid", {127'b0, valid_o}, 128'd0);
    chk("R5 reset valid last", {127'b0, valid_last_o}, 128'd0);
    chk("R5 reset chain valid", {127'b0, ch_v[10]}, 128'd0);
    rst_ni = 1'b1;
    valid_i = 1'b0;

    // R9 known-answer chain
    @(negedge clk_i);
    ch_in = 128'h00112233445566778899aabbccddeeff ^ rk[0];
    ch_vin = 1'b1;
    for (int n = 1; n <= 11; n++) begin
      @(negedge clk_i);
      if (n == 1) begin
        ch_vin = 1'b0;
        ch_in = '0;
      end
      if (n == 9) chk("R9 chain valid early", {127'b0, ch_v[10]}, 128'd0);
      if (n == 10) begin
        chk("R9 chain valid at ten", {127'b0, ch_v[10]}, 128'd1);
        chk("R9 ciphertext", ch_s[10], 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
      end
      if (n == 11) chk("R9 chain valid drops", {127'b0, ch_v[10]}, 128'd0);
    end

    // R6 zero state and key
    step('0, '0, 1'b1, "R6", 1'b0);
    step('0, '0, 1'b0, "R6", 1'b0);

    // R7 single byte at each position
    for (int b = 0; b < 16; b++) begin
      logic [127:0] s;
      s = '0;
      s[127-8*b -: 8] = 8'(8'h11 * (b + 1) + 1);
      step(s, '0, b[0], "R7", 1'b0);
    end

    // R1 R2 random states and keys
    for (int i = 0; i < 60; i++) step(rnd128(), rnd128(), 1'($urandom), "R1 R2", 1'b0);

    // R8 fixed state, single key bits flipped
    hs = rnd128();
    for (int i = 0; i < 16; i++) step(hs, 128'd1 << (8 * i + i % 8), 1'b1, "R8", 1'b0);

    // R3 state changes while key held; output must not move before the edge
    for (int i = 0; i < 8; i++) step(rnd128(), key_i, 1'b1, "R3", 1'b0);
    for (int i = 0; i < 8; i++) step(rnd128(), key_i, 1'($urandom), "R3", 1'b1);

    step('0, '0, 1'b0, "R1 R2", 1'b0);
    @(negedge clk_i);
    chk("R1 drain", state_o, q_n.pop_front());
    chk("R2 drain", state_last_o, q_f.pop_front());

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule